// File: doc/BRIEF.md
# Configuration Bus Command Bridge

This block lets a host start single transactions on a downstream configuration bus. The host uses three word registers. A data register holds the write payload, or the read result once a transaction ends. A command register holds the command word. A status register holds the outcome. Writing a command word with the launch bit set starts one request on the downstream request/response port. The request carries a controller number, a function number, a site, a stack position and a device index. The bridge then waits for the response and reports the result in the status register.

The host polls the status register until it is nonzero. Bit 0 means success and bit 1 means failure. The launch bit stays set while the transaction is outstanding and drops in the cycle the outcome is recorded. A transaction that gets no response within a parameterised number of cycles is abandoned and reported as a failure.

Top module: `cfg_cmd_bridge`

## Requirements
- R1: After reset the data, command and status registers read zero, and `dn_req_valid` is low.
- R2: A host write to the command register (byte offset 0x0A4) with bit 31 set, while no transaction is outstanding, produces exactly one cycle of `dn_req_valid` in the next cycle. The request carries the fields of the command word: bit 30 write, [29:26] controller, [25:20] function, [17:16] site, [15:12] position, [11:0] device.
- R3: While a transaction is outstanding, command bit 31 reads 1 and the status register (offset 0x0A8) reads zero.
- R4: For a write command, `dn_wdata` carries the value of the data register (offset 0x0A0) as loaded before the command.
- R5: A good response to a read loads `dn_rsp_rdata` into the data register, sets status to 1 and clears command bit 31, all at the same clock edge.
- R6: A response flagged as failed sets status to 2 and clears command bit 31. The data register keeps its value.
- R7: While a transaction is outstanding, writes to the command register and to the data register are ignored.
- R8: If no response arrives within TIMEOUT_CYC cycles of the launch, status becomes 2 and command bit 31 clears. A response that arrives later has no effect.
- R9: Any host write to the status register clears it to zero. Launching a command also clears it.
- R10: Command bits [19:18] always read zero and are never forwarded.
- R11: A command write with bit 31 clear, while idle, stores the word and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Register access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset of the register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for `host_addr` (combinational) |
| dn_req_valid | output | 1 | One-cycle request strobe |
| dn_req_write | output | 1 | Request is a write |
| dn_ctrl | output | 4 | Controller number |
| dn_func | output | 6 | Function number |
| dn_site | output | 2 | Site |
| dn_pos | output | 4 | Stack position |
| dn_dev | output | 12 | Device index |
| dn_wdata | output | 32 | Write payload |
| dn_rsp_valid | input | 1 | Response strobe |
| dn_rsp_err | input | 1 | Response reports failure |
| dn_rsp_rdata | input | 32 | Read data returned with the response |

## Verification
The bench builds the bridge with TIMEOUT_CYC set to 16. With this value the abort path is hit after a short wait, and the test can check the exact last cycle that is still busy. Random response latencies of one to five cycles stay well inside that window, so every random transaction ends on a real response. The dedicated timeout test then shows that a response arriving after the abort is ignored.

// File: rtl/cfgb_pkg.sv
// Package: shared constants for the configuration bus command bridge.
// Assumes 32-bit host registers decoded by byte offset.
package cfgb_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned START_BIT = 31;
    localparam int unsigned WRITE_BIT = 30;
    localparam int unsigned OFF_DATA  = 32'h0A0;
    localparam int unsigned OFF_CMD   = 32'h0A4;
    localparam int unsigned OFF_STAT  = 32'h0A8;
    localparam logic [WORD_W-1:0] RSVD_MASK = 32'h000C_0000;
    localparam logic [1:0] ST_DONE = 2'b01;
    localparam logic [1:0] ST_FAIL = 2'b10;
endpackage

// File: rtl/cfgb_regs.sv
// Module: host-visible register file of the bridge (data, command, status).
// Assumes the sequencer reports the outcome through a single-cycle 'finish' pulse
// that is only raised while the launch bit is set.
module cfgb_regs #(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              finish,
    input  logic              finish_err,
    input  logic [31:0]       rsp_rdata,
    output logic              launch,
    output logic              busy,
    output logic [31:0]       cmd_word,
    output logic [31:0]       data_word
);
    import cfgb_pkg::*;

    logic [31:0] cmd_q, data_q;
    logic [1:0]  stat_q;
    logic        wr_cmd, wr_data, wr_stat;

    // Decode host writes by byte offset.
    always_comb begin
        wr_cmd  = host_sel && host_we && (host_addr == ADDR_W'(OFF_CMD));
        wr_data = host_sel && host_we && (host_addr == ADDR_W'(OFF_DATA));
        wr_stat = host_sel && host_we && (host_addr == ADDR_W'(OFF_STAT));
    end

    assign busy      = cmd_q[START_BIT];
    assign launch    = wr_cmd && host_wdata[START_BIT] && !busy;
    assign cmd_word  = cmd_q;
    assign data_word = data_q;

    // Command register: accepted only when idle, launch bit dropped on finish.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (wr_cmd && !busy)
            cmd_q <= host_wdata & ~RSVD_MASK;
        else if (finish)
            cmd_q[START_BIT] <= 1'b0;
    end

    // Data register: read result capture, or host load when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (finish && !finish_err && !cmd_q[WRITE_BIT])
            data_q <= rsp_rdata;
        else if (wr_data && !busy)
            data_q <= host_wdata;
    end

    // Status register: outcome on finish, cleared by launch or any host write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else if (finish)
            stat_q <= finish_err ? ST_FAIL : ST_DONE;
        else if (launch || wr_stat)
            stat_q <= '0;
    end

    // Read-back multiplexer.
    always_comb begin
        host_rdata = '0;
        if (host_addr == ADDR_W'(OFF_DATA))      host_rdata = data_q;
        else if (host_addr == ADDR_W'(OFF_CMD))  host_rdata = cmd_q;
        else if (host_addr == ADDR_W'(OFF_STAT)) host_rdata = {30'd0, stat_q};
    end

    AST_STATUS_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> stat_q == 2'b00); // R3
    AST_BUSY_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_cmd && !finish) |=> cmd_q == $past(cmd_q)); // R7
    AST_START_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_q[START_BIT]) |-> stat_q != 2'b00); // R5
endmodule

// File: rtl/cfgb_seq.sv
// Module: transaction sequencer. Emits the request strobe, waits for the
// response and aborts after TIMEOUT_CYC outstanding cycles.
// Assumes 'launch' is only raised while idle.
module cfgb_seq #(
    parameter int unsigned TIMEOUT_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic busy,
    input  logic rsp_valid,
    input  logic rsp_err,
    output logic req_valid,
    output logic finish,
    output logic finish_err
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC) + 1;

    logic             req_q;
    logic [CNT_W-1:0] wait_cnt;
    logic             expired;

    assign expired    = busy && !rsp_valid && (wait_cnt == CNT_W'(TIMEOUT_CYC - 1));
    assign finish     = busy && (rsp_valid || expired);
    assign finish_err = expired || rsp_err;
    assign req_valid  = req_q;

    // Request strobe: one cycle after the launching write.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= launch;
    end

    // Outstanding-cycle counter for the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || launch)
            wait_cnt <= '0;
        else if (busy && !finish)
            wait_cnt <= wait_cnt + 1'b1;
    end

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q); // R2
    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> wait_cnt < CNT_W'(TIMEOUT_CYC)); // R8
endmodule

// File: rtl/cfg_cmd_bridge.sv
// Module: top of the configuration bus command bridge. Joins the register
// file and sequencer and splits the command word into downstream fields.
// Assumes one outstanding transaction at a time.
module cfg_cmd_bridge #(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned TIMEOUT_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              dn_req_valid,
    output logic              dn_req_write,
    output logic [3:0]        dn_ctrl,
    output logic [5:0]        dn_func,
    output logic [1:0]        dn_site,
    output logic [3:0]        dn_pos,
    output logic [11:0]       dn_dev,
    output logic [31:0]       dn_wdata,
    input  logic              dn_rsp_valid,
    input  logic              dn_rsp_err,
    input  logic [31:0]       dn_rsp_rdata
);
    logic        launch, busy, finish, finish_err;
    logic [31:0] cmd_word, data_word;

    cfgb_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .finish(finish), .finish_err(finish_err), .rsp_rdata(dn_rsp_rdata),
        .launch(launch), .busy(busy), .cmd_word(cmd_word), .data_word(data_word)
    );

    cfgb_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy),
        .rsp_valid(dn_rsp_valid), .rsp_err(dn_rsp_err),
        .req_valid(dn_req_valid), .finish(finish), .finish_err(finish_err)
    );

    // Field split of the held command word.
    always_comb begin
        dn_req_write = cmd_word[30];
        dn_ctrl      = cmd_word[29:26];
        dn_func      = cmd_word[25:20];
        dn_site      = cmd_word[17:16];
        dn_pos       = cmd_word[15:12];
        dn_dev       = cmd_word[11:0];
        dn_wdata     = data_word;
    end

    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> busy); // R2
endmodule

// File: tb/tb_cfg_cmd_bridge.sv
module tb_cfg_cmd_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 16;
    localparam logic [11:0] A_DATA = 12'h0A0, A_CMD = 12'h0A4, A_STAT = 12'h0A8;

    logic clk = 0, rst_n = 0;
    logic host_sel = 0, host_we = 0;
    logic [11:0] host_addr = 0;
    logic [31:0] host_wdata = 0, host_rdata;
    logic dn_req_valid, dn_req_write;
    logic [3:0] dn_ctrl, dn_pos;
    logic [5:0] dn_func;
    logic [1:0] dn_site;
    logic [11:0] dn_dev;
    logic [31:0] dn_wdata;
    logic dn_rsp_valid = 0, dn_rsp_err = 0;
    logic [31:0] dn_rsp_rdata = 0;
    int checks = 0, errors = 0;

    cfg_cmd_bridge #(.ADDR_W(12), .TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dn_req_valid(dn_req_valid), .dn_req_write(dn_req_write), .dn_ctrl(dn_ctrl),
        .dn_func(dn_func), .dn_site(dn_site), .dn_pos(dn_pos), .dn_dev(dn_dev),
        .dn_wdata(dn_wdata), .dn_rsp_valid(dn_rsp_valid), .dn_rsp_err(dn_rsp_err),
        .dn_rsp_rdata(dn_rsp_rdata));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] stored_cmd(input logic [31:0] w);
        return w & ~32'h000C_0000;
    endfunction

    function automatic logic [31:0] req_word(input logic wr, input logic [3:0] c,
            input logic [5:0] f, input logic [1:0] s, input logic [3:0] p, input logic [11:0] d);
        return {1'b0, wr, c, f, 2'b00, s, p, d};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
        host_sel = 1; host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 0; host_we = 0;
    endtask

    task automatic hread(input logic [11:0] a, output logic [31:0] d);
        host_addr = a; #1; d = host_rdata;
    endtask

    task automatic respond(input logic err, input logic [31:0] rd);
        dn_rsp_valid = 1; dn_rsp_err = err; dn_rsp_rdata = rd;
        @(negedge clk);
        dn_rsp_valid = 0; dn_rsp_err = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, data_model, cmd;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        hread(A_DATA, v); check("R1 data", v, 0);
        hread(A_CMD, v);  check("R1 cmd", v, 0);
        hread(A_STAT, v); check("R1 stat", v, 0);
        check("R1 req", {31'd0, dn_req_valid}, 0);

        // R11 command with launch clear stores word, no request; R10 reserved bits zero
        hwrite(A_CMD, 32'h7FFF_FFFF);
        check("R11 no request", {31'd0, dn_req_valid}, 0);
        hread(A_CMD, v); check("R10 reserved read zero", v, 32'h7FF3_FFFF);

        // directed write command with reserved bits set
        hwrite(A_DATA, 32'hCAFE_0001);
        hwrite(A_STAT, 0);
        hwrite(A_CMD, 32'hC00C_0000 | req_word(1, 4'h5, 6'h2A, 2'h3, 4'h9, 12'hABC));
        check("R2 req pulse", {31'd0, dn_req_valid}, 1);
        check("R10 fields", req_word(dn_req_write, dn_ctrl, dn_func, dn_site, dn_pos, dn_dev),
              req_word(1, 4'h5, 6'h2A, 2'h3, 4'h9, 12'hABC));
        check("R4 write data", dn_wdata, 32'hCAFE_0001);
        hread(A_CMD, v); check("R3 start set", {31'd0, v[31]}, 1);
        hread(A_STAT, v); check("R3 status zero", v, 0);
        @(negedge clk);
        check("R2 single pulse", {31'd0, dn_req_valid}, 0);
        // R7 writes while busy ignored
        hwrite(A_CMD, 32'h8000_0123);
        hwrite(A_DATA, 32'h1111_2222);
        check("R7 fields unchanged", {20'd0, dn_dev}, 32'hABC);
        check("R7 data unchanged", dn_wdata, 32'hCAFE_0001);
        respond(0, 32'hDEAD_BEEF);
        hread(A_STAT, v); check("R5 status done", v, 1);
        hread(A_CMD, v); check("R5 start clear", {31'd0, v[31]}, 0);
        hread(A_DATA, v); check("R5 write keeps data", v, 32'hCAFE_0001);
        data_model = 32'hCAFE_0001;

        // R9 status write clears
        hwrite(A_STAT, 32'hFFFF_FFFF);
        hread(A_STAT, v); check("R9 status cleared", v, 0);

        // R6 error response on read
        hwrite(A_CMD, 32'h8000_0042);
        @(negedge clk);
        respond(1, 32'h5555_5555);
        hread(A_STAT, v); check("R6 status fail", v, 2);
        hread(A_CMD, v); check("R6 start clear", {31'd0, v[31]}, 0);
        hread(A_DATA, v); check("R6 data kept", v, data_model);

        // R8 timeout
        hwrite(A_CMD, 32'h8000_0007);
        repeat (TMO - 1) @(negedge clk);
        hread(A_CMD, v); check("R8 busy at last cycle", {31'd0, v[31]}, 1);
        @(negedge clk);
        hread(A_CMD, v); check("R8 start cleared", {31'd0, v[31]}, 0);
        hread(A_STAT, v); check("R8 status fail", v, 2);
        respond(0, 32'h9999_9999);
        hread(A_STAT, v); check("R8 late response ignored", v, 2);
        hread(A_DATA, v); check("R8 late data ignored", v, data_model);

        // random transactions
        for (int i = 0; i < 60; i++) begin
            logic wr, er;
            logic [31:0] payload, rdv;
            int lat;
            wr = 1'($urandom);
            er = ($urandom % 8) == 0;
            payload = $urandom; rdv = $urandom;
            lat = 1 + ($urandom % 5);
            cmd = $urandom;
            cmd[31] = 1; cmd[30] = wr;
            if (wr) begin hwrite(A_DATA, payload); data_model = payload; end
            hwrite(A_CMD, cmd);
            check("R2 random request", req_word(dn_req_write, dn_ctrl, dn_func, dn_site, dn_pos, dn_dev),
                  req_word(wr, cmd[29:26], cmd[25:20], cmd[17:16], cmd[15:12], cmd[11:0]));
            if (wr) check("R4 random wdata", dn_wdata, data_model);
            repeat (lat - 1) @(negedge clk);
            hread(A_STAT, v); check("R3 random pending", v, 0);
            respond(er, rdv);
            if (!wr && !er) data_model = rdv;
            hread(A_STAT, v); check("R5 R6 random status", v, er ? 2 : 1);
            hread(A_DATA, v); check("R5 random data", v, data_model);
            hread(A_CMD, v); check("R10 random cmd", v, stored_cmd(cmd) & 32'h7FFF_FFFF);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule